// File: doc/BRIEF.md
# Rotated-Code Coherent Chip Despreader

This block turns one symbol's worth of signed soft chips into a 4-bit symbol decision. The soft chips come from coherent demodulation and RAKE combining, which happen upstream. The code set has sixteen spreading sequences, and all of them are derived from a single stored root word. Eight hypotheses are cyclic rotations of the root. The other eight are rotations of the root with every odd-indexed chip inverted. The block never stores a sequence table: each hypothesis is rebuilt from the root when the block is elaborated.

Chips arrive on a streaming interface that carries a valid strobe and a start-of-symbol marker.
- The chip that carries the marker is the cyclic extension chip, and the block discards it.
- The next N chips (N is 8 or 16) are summed into sixteen running correlations, one per hypothesis. A chip with value one adds the soft value to its sum. A chip with value zero subtracts it.
- After the last chip of the symbol, the block captures the sixteen sums and picks the largest. It then presents the winning index and its correlation value together with a one-cycle valid pulse.

Chips for the next symbol can follow with no gap.

Top module: `rot_code_despreader`

## Requirements
- R1: While reset is low and after it is released, `dec_vld` is 0. `dec_sym` and `dec_corr` are 0 until the first decision.
- R2: Chip j of hypothesis k is defined as follows. Let N be the code length and let chip c of the root be root bit N-1-c, so the most significant bit is sent first. Let step be N/8. Then chip j of hypothesis k is root chip (j - step*(k mod 8)) mod N. For k of 8 or more, that chip is inverted when its root index is odd. With N=16 and root 16'h2F53, hypothesis 1 is 16'hCBD4 and hypothesis 8 is 16'h7A06, each written chip 0 first.
- R3: The correlation for a hypothesis is the sum over the N data chips of +value where the reference chip is 1 and -value where it is 0. `dec_corr` is the winning sum as a two's-complement value. It is exact for any 8-bit input, including -128 on every chip.
- R4: `dec_sym` is the index of the largest correlation. When several correlations are equal, the lowest index wins.
- R5: The chip presented with `chip_sof` high is the extension chip. Its value has no effect on the decision.
- R6: Cycles with `chip_vld` low are ignored. Chips after the N-th data chip that arrive without a new `chip_sof` are ignored and produce no decision.
- R7: `dec_vld` is a single-cycle pulse. It appears exactly two clock cycles after the cycle in which the last data chip is presented.
- R8: Symbols can be presented back to back, with the next `chip_sof` in the cycle right after the previous last chip. Every symbol then yields its own correct decision.
- R9: A `chip_sof` that arrives before N data chips have been received abandons the partial symbol without a decision and starts a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chip_vld | input | 1 | Soft chip present this cycle |
| chip_sof | input | 1 | Marks the extension chip that opens a symbol |
| chip_val | input | CHIP_W | Signed soft chip value |
| dec_vld | output | 1 | One-cycle decision strobe |
| dec_sym | output | 4 | Decided symbol index |
| dec_corr | output | ACC_W | Signed correlation of the winning hypothesis |

## Verification
In back-to-back streaming, the extension chip of the next symbol is taken in the same cycle that the completed sums move into the decision stage. Two things can therefore collide in that cycle: clearing the accumulators and finishing the previous decision. The bench provokes this collision by streaming all sixteen symbols, and a run of pseudo-random full-range symbols, with no idle cycles between them. Each decision is judged against an independently computed correlation maximum, and each is checked to arrive exactly two cycles after its last chip. A second collision puts a marker on top of a partial symbol. The bench checks that exactly one decision results and that it belongs to the new symbol.

// File: rtl/rcd_pkg.sv
// Package rcd_pkg
// Shared constants and elaboration-time helpers for the rotated-code
// despreader. Assumes a code set of 16 hypotheses built from one root word
// of at most 16 chips, chip 0 held in the most significant used root bit.
package rcd_pkg;

    localparam int unsigned NUM_HYP  = 16;
    localparam int unsigned SYM_W    = 4;
    localparam int unsigned HALF_SET = 8;
    localparam int unsigned MAX_LEN  = 16;

    // Build the reference word of one hypothesis; bit j of the result is chip j.
    function automatic logic [MAX_LEN-1:0] hyp_word(
        input logic [MAX_LEN-1:0] root,
        input int unsigned        len,
        input int unsigned        step,
        input int unsigned        hyp
    );
        logic [MAX_LEN-1:0] w;
        int unsigned        shift;
        int unsigned        src;
        w     = '0;
        shift = (step * (hyp % HALF_SET)) % len;
        for (int unsigned j = 0; j < len; j++) begin
            src  = (j + len - shift) % len;
            w[j] = root[len-1-src];
            if (hyp >= HALF_SET && src[0]) begin
                w[j] = ~w[j];
            end
        end
        return w;
    endfunction

endpackage

// File: rtl/rcd_sequencer.sv
// Module rcd_sequencer
// Tracks the position of the incoming chip within a symbol. The chip with
// the start marker is the extension chip: it clears the correlators and is
// not forwarded. The next N_CHIPS chips are flagged as data, the last one is
// marked, and stray chips after that are dropped until the next marker.
// Assumes N_CHIPS >= 2.
module rcd_sequencer #(
    parameter int unsigned N_CHIPS = 16,
    parameter int unsigned IDX_W   = $clog2(N_CHIPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chip_vld,
    input  logic             chip_sof,
    output logic             seq_clear,
    output logic             seq_take,
    output logic             seq_last,
    output logic [IDX_W-1:0] seq_idx
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_CHIPS - 1);

    logic             active;
    logic [IDX_W-1:0] cnt;

    // Classify the current chip from the marker and the position count.
    always_comb begin
        seq_clear = chip_vld && chip_sof;
        seq_take  = chip_vld && !chip_sof && active;
        seq_last  = seq_take && (cnt == LAST_IDX);
        seq_idx   = cnt;
    end

    // Advance the data-chip position; idle after the last chip of a symbol.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (seq_clear) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (seq_take) begin
            if (seq_last) begin
                active <= 1'b0;
                cnt    <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/rcd_refgen.sv
// Module rcd_refgen
// Gives the reference chip of every hypothesis at the current data position.
// Each hypothesis word is computed from the root at elaboration; at run time
// only a per-hypothesis bit select remains. Assumes N_CHIPS <= 16.
module rcd_refgen #(
    parameter int unsigned N_CHIPS = 16,
    parameter logic [15:0] ROOT    = 16'h2F53,
    parameter int unsigned STEP    = 2,
    parameter int unsigned IDX_W   = $clog2(N_CHIPS)
) (
    input  logic [IDX_W-1:0]              idx,
    output logic [rcd_pkg::NUM_HYP-1:0]   ref_bits
);

    for (genvar k = 0; k < rcd_pkg::NUM_HYP; k++) begin : g_hyp
        localparam logic [15:0] HYP_WORD =
            rcd_pkg::hyp_word(ROOT, N_CHIPS, STEP, k);
        // Select this hypothesis' chip at the present position.
        always_comb ref_bits[k] = HYP_WORD[idx];
    end

endmodule

// File: rtl/rcd_corr_bank.sv
// Module rcd_corr_bank
// Sixteen parallel coherent correlators. Each data chip is added or
// subtracted by its hypothesis' reference bit. On the last chip the final
// sums go to a snapshot and the accumulators restart at zero, so a new
// symbol can begin on the next cycle. Assumes ACC_W holds N * 2^(CHIP_W-1).
module rcd_corr_bank #(
    parameter int unsigned CHIP_W = 8,
    parameter int unsigned ACC_W  = 13
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       seq_clear,
    input  logic                                       seq_take,
    input  logic                                       seq_last,
    input  logic signed [CHIP_W-1:0]                   chip_val,
    input  logic [rcd_pkg::NUM_HYP-1:0]                ref_bits,
    output logic [rcd_pkg::NUM_HYP-1:0][ACC_W-1:0]     snap,
    output logic                                       snap_vld
);

    logic signed [ACC_W-1:0] chip_pos;
    logic signed [ACC_W-1:0] chip_neg;

    // Widen the chip before negation so that -128 stays exact.
    always_comb begin
        chip_pos = ACC_W'(chip_val);
        chip_neg = -chip_pos;
    end

    for (genvar k = 0; k < rcd_pkg::NUM_HYP; k++) begin : g_corr
        logic signed [ACC_W-1:0] acc;
        logic signed [ACC_W-1:0] sum;

        // Running sum including the current chip's signed contribution.
        always_comb sum = acc + (ref_bits[k] ? chip_pos : chip_neg);

        // Accumulate data chips; restart on a marker or after the last chip.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                acc <= '0;
            end else if (seq_clear || seq_last) begin
                acc <= '0;
            end else if (seq_take) begin
                acc <= sum;
            end
        end

        // Capture the finished correlation of this hypothesis.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                snap[k] <= '0;
            end else if (seq_last) begin
                snap[k] <= sum;
            end
        end
    end

    // Flag a fresh snapshot for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_vld <= 1'b0;
        end else begin
            snap_vld <= seq_last;
        end
    end

endmodule

// File: rtl/rcd_argmax.sv
// Module rcd_argmax
// Picks the largest of the snapshot correlations with a balanced compare
// tree and registers the index and value. At every node the upper index
// wins only when it is strictly larger, so ties resolve to the lowest index.
// Assumes the hypothesis count is a power of two.
module rcd_argmax #(
    parameter int unsigned ACC_W = 13
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic [rcd_pkg::NUM_HYP-1:0][ACC_W-1:0]    snap,
    input  logic                                      snap_vld,
    output logic                                      dec_vld,
    output logic [rcd_pkg::SYM_W-1:0]                 dec_sym,
    output logic [ACC_W-1:0]                          dec_corr
);

    localparam int unsigned LVLS = rcd_pkg::SYM_W;
    localparam int unsigned NH   = rcd_pkg::NUM_HYP;

    logic signed [ACC_W-1:0]         tv [0:LVLS][0:NH-1];
    logic [rcd_pkg::SYM_W-1:0]       ti [0:LVLS][0:NH-1];

    // Reduce the sixteen candidates pairwise, level by level.
    always_comb begin
        for (int l = 0; l <= LVLS; l++) begin
            for (int i = 0; i < NH; i++) begin
                tv[l][i] = '0;
                ti[l][i] = '0;
            end
        end
        for (int i = 0; i < NH; i++) begin
            tv[0][i] = $signed(snap[i]);
            ti[0][i] = rcd_pkg::SYM_W'(i);
        end
        for (int l = 0; l < LVLS; l++) begin
            for (int i = 0; i < (NH >> (l + 1)); i++) begin
                if (tv[l][2*i+1] > tv[l][2*i]) begin
                    tv[l+1][i] = tv[l][2*i+1];
                    ti[l+1][i] = ti[l][2*i+1];
                end else begin
                    tv[l+1][i] = tv[l][2*i];
                    ti[l+1][i] = ti[l][2*i];
                end
            end
        end
    end

    // Register the winner and pulse the strobe for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_vld  <= 1'b0;
            dec_sym  <= '0;
            dec_corr <= '0;
        end else begin
            dec_vld <= snap_vld;
            if (snap_vld) begin
                dec_sym  <= ti[LVLS][0];
                dec_corr <= tv[LVLS][0];
            end
        end
    end

endmodule

// File: rtl/rot_code_despreader.sv
// Module rot_code_despreader
// Top level of the coherent despreader. Streams N_CHIPS+1 soft chips per
// symbol, drops the leading extension chip, correlates the rest against
// the 16 rotated / odd-inverted hypotheses of ROOT and reports the best
// index two cycles after the last chip. Assumes N_CHIPS is 8 or 16, and
// ROOT holds chip 0 in bit N_CHIPS-1.
module rot_code_despreader #(
    parameter int unsigned N_CHIPS = 16,
    parameter logic [15:0] ROOT    = 16'h2F53,
    parameter int unsigned CHIP_W  = 8,
    parameter int unsigned STEP    = N_CHIPS / 8,
    parameter int unsigned IDX_W   = $clog2(N_CHIPS),
    parameter int unsigned ACC_W   = CHIP_W + $clog2(N_CHIPS) + 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          chip_vld,
    input  logic                          chip_sof,
    input  logic signed [CHIP_W-1:0]      chip_val,
    output logic                          dec_vld,
    output logic [rcd_pkg::SYM_W-1:0]     dec_sym,
    output logic [ACC_W-1:0]              dec_corr
);

    logic                                    seq_clear;
    logic                                    seq_take;
    logic                                    seq_last;
    logic [IDX_W-1:0]                        seq_idx;
    logic [rcd_pkg::NUM_HYP-1:0]             ref_bits;
    logic [rcd_pkg::NUM_HYP-1:0][ACC_W-1:0]  snap;
    logic                                    snap_vld;

    rcd_sequencer #(
        .N_CHIPS (N_CHIPS),
        .IDX_W   (IDX_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .chip_vld  (chip_vld),
        .chip_sof  (chip_sof),
        .seq_clear (seq_clear),
        .seq_take  (seq_take),
        .seq_last  (seq_last),
        .seq_idx   (seq_idx)
    );

    rcd_refgen #(
        .N_CHIPS (N_CHIPS),
        .ROOT    (ROOT),
        .STEP    (STEP),
        .IDX_W   (IDX_W)
    ) u_ref (
        .idx      (seq_idx),
        .ref_bits (ref_bits)
    );

    rcd_corr_bank #(
        .CHIP_W (CHIP_W),
        .ACC_W  (ACC_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .seq_clear (seq_clear),
        .seq_take  (seq_take),
        .seq_last  (seq_last),
        .chip_val  (chip_val),
        .ref_bits  (ref_bits),
        .snap      (snap),
        .snap_vld  (snap_vld)
    );

    rcd_argmax #(
        .ACC_W (ACC_W)
    ) u_max (
        .clk      (clk),
        .rst_n    (rst_n),
        .snap     (snap),
        .snap_vld (snap_vld),
        .dec_vld  (dec_vld),
        .dec_sym  (dec_sym),
        .dec_corr (dec_corr)
    );

endmodule

// File: rtl/rcd_checker.sv
// Module rcd_checker
// Temporal properties of the despreader, bound to every instance of the
// top. Relates the port behaviour to the sequencer's chip classification.
module rcd_checker #(
    parameter int unsigned N_CHIPS = 16,
    parameter int unsigned CHIP_W  = 8,
    parameter int unsigned ACC_W   = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chip_vld,
    input  logic             chip_sof,
    input  logic             seq_take,
    input  logic             seq_last,
    input  logic             dec_vld,
    input  logic [ACC_W-1:0] dec_corr
);

    localparam int MAG = int'(N_CHIPS) * (2 ** (CHIP_W - 1));

    // R1: reset forces the strobe and value low.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!dec_vld && dec_corr == '0));

    // R3: the reported correlation never leaves the exact range.
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dec_vld |-> (int'($signed(dec_corr)) <= MAG &&
                     int'($signed(dec_corr)) >= -MAG));

    // R5: the marked extension chip is never counted as data.
    p_ext_dropped_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_vld && chip_sof) |-> !seq_take);

    // R6: idle cycles contribute nothing.
    p_idle_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_vld |-> !seq_take);

    // R7: a decision follows the last data chip after exactly two cycles.
    p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        seq_last |=> ##1 dec_vld);

    // R7: no decision without a last chip two cycles earlier.
    p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dec_vld |-> $past(seq_last, 2));

    // R7: the strobe lasts one cycle.
    p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dec_vld |=> !dec_vld);

endmodule

bind rot_code_despreader rcd_checker #(
    .N_CHIPS (N_CHIPS),
    .CHIP_W  (CHIP_W),
    .ACC_W   (ACC_W)
) u_rcd_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .chip_vld (chip_vld),
    .chip_sof (chip_sof),
    .seq_take (seq_take),
    .seq_last (seq_last),
    .dec_vld  (dec_vld),
    .dec_corr (dec_corr)
);

// File: tb/test_rot_code_despreader.sv
// Bench for rot_code_despreader at its default 16-chip configuration.
// Sweeps all 16 symbols, random full-range soft chips, extremes, ties,
// gaps, stray chips and aborted symbols; references computed here.
module test_rot_code_despreader;

    localparam int          N      = 16;
    localparam logic [15:0] ROOT   = 16'h2F53;
    localparam int          ACC_W  = 13;
    localparam int          MAXQ   = 128;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              chip_vld = 1'b0;
    logic              chip_sof = 1'b0;
    logic signed [7:0] chip_val = '0;
    logic              dec_vld;
    logic [3:0]        dec_sym;
    logic [ACC_W-1:0]  dec_corr;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    int    chips   [0:N-1];
    int    exp_sym [0:MAXQ-1];
    int    exp_cor [0:MAXQ-1];
    int    exp_cyc [0:MAXQ-1];
    string exp_req [0:MAXQ-1];
    int    got_sym [0:MAXQ-1];
    int    got_cor [0:MAXQ-1];
    int    got_cyc [0:MAXQ-1];
    int    n_exp = 0;
    int    n_got = 0;
    logic [31:0] rng = 32'h1234_5678;

    rot_code_despreader i_rot_code_despreader (
        .clk      (clk),
        .rst_n    (rst_n),
        .chip_vld (chip_vld),
        .chip_sof (chip_sof),
        .chip_val (chip_val),
        .dec_vld  (dec_vld),
        .dec_sym  (dec_sym),
        .dec_corr (dec_corr)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Collect every decision with its arrival cycle.
    always @(negedge clk) begin
        if (rst_n && dec_vld && n_got < MAXQ) begin
            got_sym[n_got] = int'(dec_sym);
            got_cor[n_got] = int'($signed(dec_corr));
            got_cyc[n_got] = cyc;
            n_got++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // Reference word: rotate right by 2 chips per index, odd chips inverted above 7.
    function automatic logic [15:0] ref_word(input int k);
        logic [15:0] w;
        int r;
        w = ROOT;
        if (k >= 8) w = w ^ 16'h5555;
        r = 2 * (k % 8);
        if (r != 0) w = (w >> r) | (w << (16 - r));
        return w;
    endfunction

    function automatic int corr_of(input int k);
        logic [15:0] w;
        int s;
        w = ref_word(k);
        s = 0;
        for (int j = 0; j < N; j++) s += w[15-j] ? chips[j] : -chips[j];
        return s;
    endfunction

    function automatic int next_rand();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        return int'($signed(rng[7:0]));
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chip_vld = 1'b0;
            chip_sof = 1'b0;
            chip_val = '0;
        end
    endtask

    task automatic load_symbol(input int k, input int amp);
        logic [15:0] w;
        w = ref_word(k);
        for (int j = 0; j < N; j++) chips[j] = w[15-j] ? amp : -amp;
    endtask

    // Send the extension chip then N data chips; leaves chip_vld high.
    task automatic send_symbol(input int ext_val, input int gap_every, input string req);
        int bk;
        int bc;
        int c;
        bk = 0;
        bc = corr_of(0);
        for (int k = 1; k < 16; k++) begin
            c = corr_of(k);
            if (c > bc) begin
                bc = c;
                bk = k;
            end
        end
        @(negedge clk);
        chip_vld = 1'b1;
        chip_sof = 1'b1;
        chip_val = 8'(ext_val);
        for (int j = 0; j < N; j++) begin
            if (gap_every > 0 && j > 0 && (j % gap_every) == 0) begin
                @(negedge clk);
                chip_vld = 1'b0;
                chip_sof = 1'b0;
                chip_val = 8'sd99;
            end
            @(negedge clk);
            chip_vld = 1'b1;
            chip_sof = 1'b0;
            chip_val = 8'(chips[j]);
        end
        if (n_exp < MAXQ) begin
            exp_sym[n_exp] = bk;
            exp_cor[n_exp] = bc;
            exp_cyc[n_exp] = cyc + 2;
            exp_req[n_exp] = req;
            n_exp++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        // R1: outputs quiet in and after reset
        check(dec_vld == 1'b0, "R1", int'(dec_vld), 0);
        rst_n = 1'b1;
        idle(3);
        check(dec_vld == 1'b0, "R1", int'(dec_vld), 0);
        check(dec_sym == 4'd0, "R1", int'(dec_sym), 0);
        check(dec_corr == '0, "R1", int'(dec_corr), 0);

        // R2: reference words against known chip patterns
        check(ref_word(1) == 16'hCBD4, "R2", int'(ref_word(1)), 32'hCBD4);
        check(ref_word(8) == 16'h7A06, "R2", int'(ref_word(8)), 32'h7A06);

        // R2, R8: all sixteen symbols at +-64, back to back, extension +127
        for (int k = 0; k < 16; k++) begin
            load_symbol(k, 64);
            send_symbol(127, 0, "R2");
        end
        idle(4);
        check(n_got == 16, "R8", n_got, 16);

        // R5: extension chip value has no effect
        load_symbol(5, 64);
        send_symbol(-128, 0, "R5");
        load_symbol(5, 64);
        send_symbol(0, 0, "R5");
        // R6: idle cycles inside a symbol are ignored
        load_symbol(12, 40);
        send_symbol(17, 3, "R6");
        idle(4);

        // R3, R4, R8: pseudo-random full-range chips, back to back
        for (int s = 0; s < 24; s++) begin
            for (int j = 0; j < N; j++) chips[j] = next_rand();
            send_symbol(next_rand(), 0, "R4");
        end
        // R3: extremes on every chip
        for (int j = 0; j < N; j++) chips[j] = -128;
        send_symbol(-128, 0, "R3");
        for (int j = 0; j < N; j++) chips[j] = 127;
        send_symbol(127, 0, "R3");
        // R4: full tie resolves to index 0
        for (int j = 0; j < N; j++) chips[j] = 0;
        send_symbol(100, 0, "R4");
        idle(4);

        // R6: stray chips after the last data chip produce nothing
        load_symbol(9, 50);
        send_symbol(3, 0, "R6");
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chip_vld = 1'b1;
            chip_sof = 1'b0;
            chip_val = 8'sd120;
        end
        idle(6);
        check(n_got == n_exp, "R6", n_got, n_exp);

        // R9: a marker inside a partial symbol restarts it
        base = n_got;
        @(negedge clk);
        chip_vld = 1'b1;
        chip_sof = 1'b1;
        chip_val = 8'sd5;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chip_sof = 1'b0;
            chip_val = 8'sd127;
        end
        load_symbol(14, 30);
        send_symbol(-7, 0, "R9");
        idle(6);
        check(n_got == base + 1, "R9", n_got, base + 1);

        // Compare every decision: symbol, value (R3) and arrival cycle (R7)
        check(n_got == n_exp, "R7", n_got, n_exp);
        for (int i = 0; i < n_exp && i < n_got; i++) begin
            check(got_sym[i] == exp_sym[i], exp_req[i], got_sym[i], exp_sym[i]);
            check(got_cor[i] == exp_cor[i], "R3", got_cor[i], exp_cor[i]);
            check(got_cyc[i] == exp_cyc[i], "R7", got_cyc[i], exp_cyc[i]);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule